// File: doc/BRIEF.md
# Pipelined Array Increment Engine

This block walks a contiguous region of word-sized elements in a memory and adds one to each of them. Rather than finishing one element before starting the next, it overlaps the work of several elements. A new load leaves the block every cycle. Older elements meanwhile wait for their read data, get incremented, or get written back. A region of n elements therefore costs n+3 cycles instead of four cycles per element.

A controller pulses `start_i` with a byte base address and an element count, then waits for `done_o`. The block drives one read port and one write port of a synchronous memory. That memory returns read data exactly two cycles after the read request. Each element is loaded in some cycle k, incremented in cycle k+2 when its data arrives, and stored in cycle k+3. The incremented values sit in a ring of four value slots that are reused in turn. Separate read and write pointers both start at the base and step by four bytes.

Top module: `incr_pipe_engine`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `rd_en_o` and `wr_en_o` are 0 until a start is accepted.
- R2: After a start with count n>0 is accepted, `rd_en_o` is 1 for exactly n consecutive cycles, beginning the cycle after start. The k-th load (k from 0) uses byte address base+4k.
- R3: Each element is stored exactly three cycles after its load, so it consumes read data two cycles after the load. At most one load and one store occur per cycle.
- R4: The store of element k uses byte address base+4k and writes the loaded value plus one modulo 2^32, so 0xFFFFFFFF becomes 0x00000000.
- R5: From the first load cycle to the last store cycle inclusive, a run of n>0 elements spans exactly n+3 cycles.
- R6: `done_o` is a single-cycle pulse that comes in the cycle right after the final store.
- R7: A start with count 0 raises `done_o` in the cycle after start and issues no load and no store.
- R8: No memory word outside [base, base+4n) is read or written by a run.
- R9: A start pulse that arrives while a run is in progress is ignored. The run's addresses, timing and single done pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, honoured only when idle |
| base_i | input | AW | Byte address of the first element |
| count_i | input | CW | Number of elements |
| done_o | output | 1 | One-cycle completion pulse |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | AW | Memory read byte address |
| rd_data_i | input | DW | Read data, valid two cycles after the request |
| wr_en_o | output | 1 | Memory write request |
| wr_addr_o | output | AW | Memory write byte address |
| wr_data_o | output | DW | Memory write data |

## Verification
The assertions assume the memory delivers read data exactly two cycles after each request, with no stalls. They also assume reset is held for at least three cycles, so that the three-cycle look-back in the load-to-store check only sees reset values. The address-step checks further assume that a region never wraps past the top of the address space. The bench stays inside these limits in several ways. Its memory model has a fixed two-stage read path, and it holds reset for five cycles. It chooses every base and count, random or directed, so that the whole region lies inside the modelled memory.

// File: rtl/incp_pkg.sv
package incp_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  localparam int unsigned RING_SLOTS = 4;
endpackage

// File: rtl/incp_issue.sv
module incp_issue import incp_pkg::*; #(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  input  logic          fin_i,
  output logic          launch_o,
  output logic          zero_kick_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o
);
  run_state_t    state_q;
  logic [CW-1:0] remain_q;
  logic          idle_start;

  assign idle_start  = (state_q == ST_IDLE) && start_i;
  assign launch_o    = idle_start && (count_i != '0);
  assign zero_kick_o = idle_start && (count_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      remain_q  <= '0;
      rd_en_o   <= 1'b0;
      rd_addr_o <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (launch_o) begin
            state_q   <= ST_RUN;
            rd_en_o   <= 1'b1;
            rd_addr_o <= base_i;
            remain_q  <= count_i - 1'b1;
          end
        end
        default: begin
          if (rd_en_o) begin
            if (remain_q == '0) begin
              rd_en_o <= 1'b0;
            end else begin
              remain_q  <= remain_q - 1'b1;
              rd_addr_o <= rd_addr_o + AW'(STEP);
            end
          end
          if (fin_i) state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/incp_ring.sv
module incp_ring import incp_pkg::*; #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          wr_en_i,
  output logic          wait_v_o,
  output logic          arrive_v_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int SIDX = $clog2(RING_SLOTS);

  logic [SIDX-1:0] put_idx_q;
  logic [SIDX-1:0] take_idx_q;
  logic [DW-1:0]   slot_q [RING_SLOTS];
  logic [DW-1:0]   bumped;

  assign bumped = rd_data_i + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_v_o   <= 1'b0;
      arrive_v_o <= 1'b0;
      put_idx_q  <= '0;
      take_idx_q <= '0;
    end else begin
      wait_v_o   <= rd_en_i;
      arrive_v_o <= wait_v_o;
      if (arrive_v_o) put_idx_q  <= put_idx_q + 1'b1;
      if (wr_en_i)    take_idx_q <= take_idx_q + 1'b1;
    end
  end

  for (genvar s = 0; s < RING_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (arrive_v_o && (put_idx_q == SIDX'(s))) slot_q[s] <= bumped;
    end
  end

  assign wr_data_o = slot_q[take_idx_q];
endmodule

// File: rtl/incp_store.sv
module incp_store #(
  parameter int AW = 16,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          launch_i,
  input  logic [AW-1:0] base_i,
  input  logic          arrive_v_i,
  input  logic          wait_v_i,
  input  logic          rd_en_i,
  input  logic          zero_kick_i,
  output logic          fin_o,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          done_o
);
  logic [AW-1:0] wptr_q;

  assign fin_o = wr_en_o && !rd_en_i && !wait_v_i && !arrive_v_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q    <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      done_o    <= 1'b0;
    end else begin
      wr_en_o <= arrive_v_i;
      done_o  <= fin_o || zero_kick_i;
      if (launch_i) begin
        wptr_q <= base_i;
      end else if (arrive_v_i) begin
        wr_addr_o <= wptr_q;
        wptr_q    <= wptr_q + AW'(STEP);
      end
    end
  end
endmodule

// File: rtl/incr_pipe_engine.sv
module incr_pipe_engine #(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] count_i,
  output logic          done_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int STEP = DW / 8;

  logic launch, zero_kick, fin, wait_v, arrive_v;

  incp_issue #(.AW(AW), .CW(CW), .STEP(STEP)) issue_i (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
    .count_i(count_i), .fin_i(fin), .launch_o(launch),
    .zero_kick_o(zero_kick), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o)
  );

  incp_ring #(.DW(DW)) ring_i (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_o), .rd_data_i(rd_data_i),
    .wr_en_i(wr_en_o), .wait_v_o(wait_v), .arrive_v_o(arrive_v),
    .wr_data_o(wr_data_o)
  );

  incp_store #(.AW(AW), .STEP(STEP)) store_i (
    .clk(clk), .rst(rst), .launch_i(launch), .base_i(base_i),
    .arrive_v_i(arrive_v), .wait_v_i(wait_v), .rd_en_i(rd_en_o),
    .zero_kick_i(zero_kick), .fin_o(fin), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .done_o(done_o)
  );
endmodule

// File: rtl/incp_checker.sv
module incp_checker #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done_o,
  input logic          rd_en_o,
  input logic [AW-1:0] rd_addr_o,
  input logic [DW-1:0] rd_data_i,
  input logic          wr_en_o,
  input logic [AW-1:0] wr_addr_o,
  input logic [DW-1:0] wr_data_o
);
  localparam int STEP = DW / 8;

  p_load_step_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_o && $past(rd_en_o)) |-> (rd_addr_o == $past(rd_addr_o) + AW'(STEP)));

  p_store_lag_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> $past(rd_en_o, 3));

  p_store_step_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) + AW'(STEP)));

  p_wrap_incr_r4: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> (wr_data_o == $past(rd_data_i) + 1'b1));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!rd_en_o && !wr_en_o));
endmodule

bind incr_pipe_engine incp_checker #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .done_o(done_o), .rd_en_o(rd_en_o),
  .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .wr_en_o(wr_en_o),
  .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
);

// File: tb/incr_pipe_engine_tb_top.sv
module incr_pipe_engine_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 16;
  localparam int WORDS = 512;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [CW-1:0] count_i = '0;
  logic          done_o, rd_en_o, wr_en_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [DW-1:0] rd_data_i, wr_data_o;

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] gold [WORDS];
  logic [DW-1:0] rd_p1;
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  incr_pipe_engine #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i),
    .count_i(count_i), .done_o(done_o), .rd_en_o(rd_en_o),
    .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i), .wr_en_o(wr_en_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  always @(posedge clk) begin
    if (wr_en_o) mem[wr_addr_o[10:2]] <= wr_data_o;
    rd_p1     <= mem[rd_addr_o[10:2]];
    rd_data_i <= rd_p1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] incr(input logic [DW-1:0] v);
    return v + 32'd1;
  endfunction

  task automatic run_case(input int bw, input int n, input bit all_ones, input bit poke);
    int rd_bad = 0, wr_bad = 0, loads = 0, stores = 0, dones = 0;
    int first_rd = -1, last_wr = -1, done_at = -1, outside = 0;
    for (int w = 0; w < WORDS; w++) begin
      mem[w] = (all_ones && w >= bw && w < bw + n) ? 32'hFFFF_FFFF : $urandom;
      gold[w] = mem[w];
    end
    @(negedge clk);
    start_i = 1'b1; base_i = AW'(bw * 4); count_i = CW'(n);
    for (int i = 1; i <= n + 8; i++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (poke && i == 5) begin
        start_i = 1'b1; base_i = AW'(4); count_i = CW'(3);
      end
      if (rd_en_o) begin
        loads++;
        if (first_rd < 0) first_rd = i;
        if (i < 1 || i > n || rd_addr_o != AW'((bw + i - 1) * 4)) rd_bad++;
      end
      if (wr_en_o) begin
        stores++;
        last_wr = i;
        if (i < 4 || i > n + 3 || wr_addr_o != AW'((bw + i - 4) * 4)
            || wr_data_o != incr(gold[bw + i - 4])) wr_bad++;
      end
      if (done_o) begin dones++; done_at = i; end
    end
    start_i = 1'b0;
    for (int w = 0; w < WORDS; w++) begin
      if (w >= bw && w < bw + n) begin
        if (mem[w] != incr(gold[w])) wr_bad++;
      end else if (mem[w] != gold[w]) outside++;
    end
    if (n == 0) begin
      check(loads == 0 && stores == 0, "R7 no access", loads + stores, 0);
      check(dones == 1 && done_at == 1, "R7 done cycle", done_at, 1);
    end else begin
      check(loads == n && rd_bad == 0, "R2 loads", loads - rd_bad, n);
      check(stores == n && first_rd == 1, "R3 store lag", stores, n);
      check(wr_bad == 0, "R4 store data/addr", wr_bad, 0);
      check(last_wr - first_rd + 1 == n + 3, "R5 cycle count", last_wr - first_rd + 1, n + 3);
      check(dones == 1 && done_at == last_wr + 1, "R6 done pulse", done_at, last_wr + 1);
      if (poke) check(dones == 1 && rd_bad == 0, "R9 busy start ignored", rd_bad, 0);
    end
    check(outside == 0, "R8 outside region", outside, 0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (5) @(negedge clk);
    check(!done_o && !rd_en_o && !wr_en_o, "R1 reset idle", int'(done_o), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!done_o && !rd_en_o && !wr_en_o, "R1 idle after reset", int'(rd_en_o), 0);
    run_case(16, 1, 1'b0, 1'b0);
    run_case(20, 2, 1'b0, 1'b0);
    run_case(30, 4, 1'b1, 1'b0);  // R4 wrap of 0xFFFFFFFF
    run_case(40, 10, 1'b0, 1'b0);
    run_case(50, 0, 1'b0, 1'b0);
    run_case(64, 300, 1'b0, 1'b0);
    run_case(100, 10, 1'b0, 1'b1); // R9 start while busy
    for (int r = 0; r < 8; r++) begin
      int n, bw;
      n = 1 + int'($urandom % 40);
      bw = int'($urandom % (WORDS - n));
      run_case(bw, n, 1'b0, 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule